// File: doc/BRIEF.md
# Core Prioritized Interrupt Controller

This block sits between the interrupt sources of a processor subsystem and the core itself. It offers sixteen fixed-priority levels. Level 0 carries a reset request, level 1 a non-maskable request, levels 2 and 3 are held unused, and levels 4 to 15 take twelve external maskable lines. Every request is captured on its rising edge into a pending register. The enabled pending level with the smallest number is offered to the core as a valid flag plus a 4-bit level number. When the core acknowledges a level, that level's pending bit is dropped.

A small register port lets software program the per-level enable mask, set pending bits, clear pending bits, and read back both the mask and the pending state. A single global enable input gates all maskable levels together. Reset and NMI are never gated.

Top module: `core_prio_intc`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_level` is 0, and both the pending register (read at address 1) and the mask register (read at address 0) read as zero.
- R2: A rising edge on `ext_irq[k]` sets the pending bit of level k+4 at that clock edge, so a one-cycle pulse is kept. A line that stays high creates no further request after its level is acknowledged.
- R3: Among the enabled pending maskable levels, the one with the smallest number is presented: level 4 is highest and level 15 is lowest.
- R4: A pending maskable level whose mask bit is 0 is not presented, and its pending bit stays set. Mask bit n (address 0, written and read) enables level n for n in 4..15. Mask bits 3..0 read as 0.
- R5: With `glb_en` low, no level from 4 to 15 is presented, whatever the mask holds.
- R6: A pending reset request (level 0) is presented ahead of everything. A pending NMI (level 1) is presented ahead of every maskable level. Neither depends on the mask or on `glb_en`. Both are captured on the rising edges of `rst_req` and `nmi_req`.
- R7: Levels 2 and 3 never become pending and are never presented. Software writes to pending bits 3..0 have no effect.
- R8: Acknowledging level L (`ack` high with `ack_level` = L) clears only pending bit L. If a new edge for L arrives in the same cycle, bit L stays set.
- R9: A write to address 1 sets the pending bits of levels 4..15 wherever the write data holds a 1. A write to address 2 clears them wherever the write data holds a 1. Reading address 1 returns the pending register, and reading addresses 2 and 3 returns 0.
- R10: When no enabled level is pending, `irq_valid` is 0 and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Reset request source, level 0, edge captured |
| nmi_req | input | 1 | Non-maskable request source, level 1, edge captured |
| ext_irq | input | 12 | External lines; bit k drives level k+4 |
| glb_en | input | 1 | Global enable for levels 4..15 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 set/read pending, 2 clear pending |
| reg_wdata | input | 16 | Register write data, one bit per level |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| ack | input | 1 | Core acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_valid | output | 1 | An enabled request is pending |
| irq_level | output | 4 | Highest-priority enabled pending level |

## Verification
The bench runs mask and global-enable patterns in which the winning level is masked out. A design that kept a fixed order without the mask would present that masked level. It sends a software set of bits 2 and 3 and reads back. A design without the reserved-bit filter would show the bits pending or present level 2. It acknowledges a level in the same cycle as a fresh edge on that line. A design that lets clear beat set would lose the new request. It also holds a line high across its acknowledge. A level-sensitive design would fire that line again. Finally, reset and NMI are pulsed with the mask and global enable both off. Gating them would leave the core with no request.

// File: rtl/core_prio_intc.sv
module core_prio_intc #(
  parameter int LEVELS    = 16,
  parameter int FIRST_EXT = 4,
  localparam int LW   = $clog2(LEVELS),
  localparam int NEXT = LEVELS - FIRST_EXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              nmi_req,
  input  logic [NEXT-1:0]   ext_irq,
  input  logic              glb_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [LEVELS-1:0] reg_wdata,
  output logic [LEVELS-1:0] reg_rdata,
  input  logic              ack,
  input  logic [LW-1:0]     ack_level,
  output logic              irq_valid,
  output logic [LW-1:0]     irq_level
);

  localparam logic [LEVELS-1:0] EXT_BITS = {{NEXT{1'b1}}, {FIRST_EXT{1'b0}}};
  localparam logic [LEVELS-1:0] FIX_BITS = {{(LEVELS-2){1'b0}}, 2'b11};
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_SET  = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;

  logic [LEVELS-1:0] pend, mask_q, hw_set, sw_set, sw_clr, ack_clr, elig;
  logic [NEXT-1:0]   ext_prev;
  logic              rst_prev, nmi_prev;

  always_comb begin
    hw_set = '0;
    hw_set[0] = rst_req & ~rst_prev;
    hw_set[1] = nmi_req & ~nmi_prev;
    hw_set[LEVELS-1:FIRST_EXT] = ext_irq & ~ext_prev;
  end

  assign sw_set  = (reg_wr && reg_addr == A_SET) ? (reg_wdata & EXT_BITS) : '0;
  assign sw_clr  = (reg_wr && reg_addr == A_CLR) ? (reg_wdata & EXT_BITS) : '0;
  assign ack_clr = ack ? ({{(LEVELS-1){1'b0}}, 1'b1} << ack_level) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      mask_q   <= '0;
      ext_prev <= '0;
      rst_prev <= 1'b0;
      nmi_prev <= 1'b0;
    end else begin
      ext_prev <= ext_irq;
      rst_prev <= rst_req;
      nmi_prev <= nmi_req;
      pend     <= ((pend & ~(sw_clr | ack_clr)) | hw_set | sw_set) & (EXT_BITS | FIX_BITS);
      if (reg_wr && reg_addr == A_MASK)
        mask_q <= reg_wdata & EXT_BITS;
    end
  end

  assign elig = pend & (FIX_BITS | (mask_q & {LEVELS{glb_en}}));

  always_comb begin
    irq_level = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (elig[i]) irq_level = LW'(i);
  end

  assign irq_valid = |elig;

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_SET:   reg_rdata = pend;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/core_prio_intc_chk.sv
module core_prio_intc_chk #(
  parameter int LEVELS    = 16,
  parameter int FIRST_EXT = 4,
  localparam int LW   = $clog2(LEVELS),
  localparam int NEXT = LEVELS - FIRST_EXT
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEXT-1:0]   ext_irq,
  input logic              irq_valid,
  input logic [LW-1:0]     irq_level,
  input logic [LEVELS-1:0] pend
);

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend[FIRST_EXT-1:2] == '0); // R7

  AST_RSVD_NOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level < 2 || irq_level >= FIRST_EXT)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_level == '0); // R10

  AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> (irq_valid && irq_level == '0)); // R6

  AST_NMI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !pend[0]) |-> (irq_valid && irq_level == 1)); // R6

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_irq[0]) |=> pend[FIRST_EXT]); // R2

endmodule

bind core_prio_intc core_prio_intc_chk #(.LEVELS(LEVELS), .FIRST_EXT(FIRST_EXT)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
  .irq_valid(irq_valid), .irq_level(irq_level), .pend(pend)
);

// File: tb/core_prio_intc_tb_top.sv
module core_prio_intc_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        rst_req = 0, nmi_req = 0, glb_en = 0, reg_wr = 0, ack = 0;
  logic [11:0] ext_irq = '0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  ack_level = '0, irq_level;
  logic        irq_valid;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  core_prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
    .ext_irq(ext_irq), .glb_en(glb_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .ack_level(ack_level),
    .irq_valid(irq_valid), .irq_level(irq_level)
  );

  // mask, glb_en, set bits, expected valid, expected level
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {16'hFFF0, 1'b1, 16'h0010, 1'b1, 4'd4},   // R3
    {16'hFFF0, 1'b1, 16'h8000, 1'b1, 4'd15},  // R3
    {16'hFFF0, 1'b1, 16'h8100, 1'b1, 4'd8},   // R3
    {16'hFEF0, 1'b1, 16'h8100, 1'b1, 4'd15},  // R4
    {16'h0000, 1'b1, 16'hFFF0, 1'b0, 4'd0},   // R4 R10
    {16'hFFF0, 1'b0, 16'hFFF0, 1'b0, 4'd0},   // R5
    {16'h0F00, 1'b1, 16'hF0F0, 1'b0, 4'd0},   // R4
    {16'h0F00, 1'b1, 16'hFFF0, 1'b1, 4'd8},   // R4
    {16'hFFF0, 1'b1, 16'h000C, 1'b0, 4'd0},   // R7
    {16'h3000, 1'b1, 16'h3000, 1'b1, 4'd12}   // R3
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic v, input logic [3:0] l);
    chk({tag, " valid"}, {15'd0, irq_valid}, {15'd0, v});
    chk({tag, " level"}, {12'd0, irq_level}, {12'd0, l});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_ack(input logic [3:0] l);
    @(negedge clk);
    ack = 1; ack_level = l;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic pulse_ext(input int k);
    @(negedge clk);
    ext_irq[k] = 1;
    @(negedge clk);
    ext_irq[k] = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_out("R1 reset", 1'b0, 4'd0);
    rd(2'd1, rv); chk("R1 pending after reset", rv, 16'h0000);
    rd(2'd0, rv); chk("R1 mask after reset", rv, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][37:22]);
      glb_en = VEC[i][21];
      wr(2'd2, 16'hFFFF);
      wr(2'd1, VEC[i][20:5]);
      chk_out($sformatf("R3/R4/R5/R7 vector %0d", i), VEC[i][4], VEC[i][3:0]);
    end
    rd(2'd1, rv); chk("R9 pending readback", rv, 16'h3000);
    rd(2'd0, rv); chk("R4 mask readback", rv, 16'h3000);
    rd(2'd2, rv); chk("R9 addr 2 reads zero", rv, 16'h0000);

    // masked bit remains pending
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'hFEF0);
    wr(2'd1, 16'h0100);
    chk_out("R4 masked not presented", 1'b0, 4'd0);
    rd(2'd1, rv); chk("R4 masked still pending", rv, 16'h0100);

    // software set and clear
    wr(2'd1, 16'hFFFF);
    rd(2'd1, rv); chk("R7 R9 set ignores low bits", rv, 16'hFFF0);
    wr(2'd2, 16'h00F0);
    rd(2'd1, rv); chk("R9 clear selected bits", rv, 16'hFF00);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'hFFF0);
    glb_en = 1;

    // edge capture, acks, held line
    pulse_ext(1);
    chk_out("R2 pulse captured", 1'b1, 4'd5);
    @(negedge clk); ext_irq[3] = 1;
    @(negedge clk);
    chk_out("R2 R3 level 5 over 7", 1'b1, 4'd5);
    do_ack(4'd5);
    chk_out("R8 ack 5 leaves 7", 1'b1, 4'd7);
    rd(2'd1, rv); chk("R8 only bit 5 cleared", rv, 16'h0080);
    do_ack(4'd7);
    chk_out("R2 held line no retrigger", 1'b0, 4'd0);
    @(negedge clk); ext_irq[3] = 0;

    // ack with simultaneous new edge
    pulse_ext(0);
    chk_out("R2 level 4 captured", 1'b1, 4'd4);
    @(negedge clk); ack = 1; ack_level = 4'd4; ext_irq[0] = 1;
    @(negedge clk); ack = 0; ext_irq[0] = 0;
    chk_out("R8 edge during ack re-sets", 1'b1, 4'd4);
    do_ack(4'd4);
    chk_out("R8 final ack clears", 1'b0, 4'd0);

    // reset and NMI bypass gating
    wr(2'd0, 16'h0000);
    glb_en = 0;
    wr(2'd1, 16'h0040);
    @(negedge clk); nmi_req = 1;
    @(negedge clk); nmi_req = 0;
    chk_out("R6 NMI ungated", 1'b1, 4'd1);
    @(negedge clk); rst_req = 1;
    @(negedge clk); rst_req = 0;
    chk_out("R6 reset request top", 1'b1, 4'd0);
    do_ack(4'd0);
    chk_out("R6 NMI after reset ack", 1'b1, 4'd1);
    do_ack(4'd1);
    chk_out("R10 idle after acks", 1'b0, 4'd0);
    glb_en = 1;
    wr(2'd0, 16'h0040);
    chk_out("R5 R6 maskable after NMI", 1'b1, 4'd6);
    summary();
  end

endmodule